// File: doc/BRIEF.md
# Flash Access Guard

The flash access guard sits between the two flash requesters and the flash array. The requesters are CPU firmware and the debug port. Every read, write, page erase, lock-byte write or whole-device erase is judged in a single cycle against a page-lock policy. The outcome is one of three:

- **grant**: the request may go on to the array.
- **drop**: the request is silently discarded, without a reset. This applies only to the debug port.
- **flash-error reset**: the device is reset and a sticky error flag is raised. This applies only to firmware.

The decision depends on who asks, which page is targeted, and whether the page the firmware is running from is itself locked.

The lock state is a vector with one bit per page, where a 0 bit means locked. The page holding the lock byte is the last page, and it is implicitly locked as soon as any page is locked. The guard keeps an active copy of the stored lock byte. This copy is loaded only when a reset ends: either the external reset or the guard's own flash-error reset. A newly written lock value therefore takes effect only after the next reset. A debug-port device erase wipes the whole array and returns the active copy to all-unlocked.

Top module: `flg_guard`

## Requirements
- R1: While `rst_n` is low, `grant`, `drop`, `err_reset` and `err_flag` are 0. In the first cycle after release, requests are judged against `lock_stored`, and from the next edge `lock_active` equals `lock_stored`.
- R2: A request accepted in the cycle where `req_valid` is 1 yields exactly one one-cycle pulse of `grant`, `drop` or `err_reset` in the next cycle. With no request, none of them pulses. Op codes: 0 read, 1 write, 2 page erase, 3 lock-byte write, 4 device erase; codes 5 to 7 are refused.
- R3: Bit i of the lock vector covers page i, and 0 means locked. Firmware (`req_src`=0) running from an unlocked page is refused a read, write or erase of a locked page. Firmware running from a locked page is granted it.
- R4: When any lock bit is 0, page NUM_PAGES-1 (the lock-byte page, also the target of every op-3 request) counts as locked.
- R5: A refused firmware request pulses `err_reset`, sets `err_flag`, and reloads `lock_active` from `lock_stored`. `err_flag` stays 1 through flash-error resets and is cleared only by `rst_n`.
- R6: A refused debug request (`req_src`=1) pulses `drop` and never `err_reset`. Debug reads, writes and erases of locked, non-reserved pages are granted.
- R7: A lock-byte write whose data has a 1 where `lock_stored` has a 0 is refused. A write that only clears bits is allowed.
- R8: A granted lock-byte write leaves `lock_active` unchanged until the next reset.
- R9: A page erase of the lock-byte page while any page is locked is refused. A device erase is granted only from the debug port, and it sets `lock_active` to all ones. From firmware it is refused.
- R10: Any read, write or erase of a page index at or above NUM_PAGES (the reserved area) is refused.
- R11: A firmware write, erase or lock-byte write is refused unless both `vmon_en` and `vmon_rst_src` are 1. Reads are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low device reset (not a flash-error reset) |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | 1 | 0 firmware, 1 debug port |
| req_op | input | 3 | Operation code |
| req_page | input | PAGE_AW | Target page (ignored for ops 3 and 4) |
| exec_page | input | PAGE_AW | Page the firmware is executing from |
| lock_wdata | input | NUM_PAGES | New lock value for op 3 |
| lock_stored | input | NUM_PAGES | Lock byte as currently held in the array |
| vmon_en | input | 1 | Supply monitor enabled |
| vmon_rst_src | input | 1 | Supply monitor enabled as a reset source |
| grant | output | 1 | Request allowed (one-cycle pulse) |
| drop | output | 1 | Request silently discarded (one-cycle pulse) |
| err_reset | output | 1 | Flash-error device reset request (one-cycle pulse) |
| err_flag | output | 1 | Sticky flash-error reset cause |
| lock_active | output | NUM_PAGES | Lock state in force |

## Verification
The decision logic is exercised with the same page target under four varying factors: requester, locked versus unlocked executing page, supply-monitor state, and lock-byte value. Each step isolates exactly one rule.

- Firmware reads of a locked page from an unlocked page versus from a locked page separate the execution-location rule from the plain lock check.
- Reads versus writes of the lock-byte page with other pages locked show the implicit lock.
- Identical refused requests from the debug port and from firmware tell drop from reset.
- A lock-byte write followed by a read of the newly locked page, before and after a reset, shows that the lock takes effect only after the reset.
- Lock-byte values that clear versus set bits, and page indices at and above the reserved boundary, cover the remaining refusals.

// File: rtl/flg_pkg.sv
package flg_pkg;

    localparam logic SRC_FW  = 1'b0;
    localparam logic SRC_DBG = 1'b1;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_ERASE    = 3'd2,
        OP_LOCKWR   = 3'd3,
        OP_DEVERASE = 3'd4
    } flg_op_e;

    typedef enum logic [1:0] {
        VRD_GRANT = 2'd0,
        VRD_DROP  = 2'd1,
        VRD_FAULT = 2'd2
    } flg_verdict_e;

endpackage

// File: rtl/flg_lock_map.sv
// Expands the lock vector into a per-page "protected" vector; the lock-byte
// page additionally becomes protected as soon as any page is locked.
module flg_lock_map #(
    parameter int NUM_PAGES = 8
) (
    input  logic [NUM_PAGES-1:0] lock_eff,
    output logic [NUM_PAGES-1:0] locked_vec,
    output logic                 any_locked
);
    localparam int LOCK_PAGE = NUM_PAGES - 1;

    assign any_locked = ~&lock_eff;

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
        if (i == LOCK_PAGE) begin : g_lockpg
            assign locked_vec[i] = ~lock_eff[i] | any_locked;
        end else begin : g_plain
            assign locked_vec[i] = ~lock_eff[i];
        end
    end
endmodule

// File: rtl/flg_page_class.sv
// Classifies one page index: reserved (beyond the array) and protected.
module flg_page_class #(
    parameter int NUM_PAGES = 8,
    parameter int PAGE_AW   = 4
) (
    input  logic [PAGE_AW-1:0]   page,
    input  logic [NUM_PAGES-1:0] locked_vec,
    output logic                 locked,
    output logic                 reserved
);
    localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx      = page[IDX_W-1:0];
        reserved = (page >= PAGE_AW'(NUM_PAGES));
        locked   = reserved ? 1'b0 : locked_vec[idx];
    end
endmodule

// File: rtl/flg_policy.sv
// Pure combinational verdict for one request.
module flg_policy
    import flg_pkg::*;
(
    input  logic         src,
    input  flg_op_e      op,
    input  logic         tgt_locked,
    input  logic         tgt_rsvd,
    input  logic         exec_locked,
    input  logic         exec_rsvd,
    input  logic         tgt_is_lock,
    input  logic         any_locked,
    input  logic         unlock_try,
    input  logic         vmon_ok,
    output flg_verdict_e verdict,
    output logic         dev_erase
);
    logic refuse;
    logic modifies;
    logic exec_priv;

    always_comb begin
        refuse    = 1'b0;
        dev_erase = 1'b0;
        modifies  = (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_LOCKWR);
        exec_priv = exec_locked && !exec_rsvd;

        case (op)
            OP_READ, OP_WRITE, OP_ERASE: begin
                if (tgt_rsvd) refuse = 1'b1;
                if (op == OP_ERASE && tgt_is_lock && any_locked) refuse = 1'b1;
            end
            OP_LOCKWR: begin
                if (unlock_try) refuse = 1'b1;
            end
            OP_DEVERASE: begin
                if (src == SRC_DBG) dev_erase = 1'b1;
                else                refuse    = 1'b1;
            end
            default: refuse = 1'b1;
        endcase

        if (src == SRC_FW) begin
            if (modifies && !vmon_ok)       refuse = 1'b1;
            if (tgt_locked && !exec_priv)   refuse = 1'b1;
        end

        if (!refuse)              verdict = VRD_GRANT;
        else if (src == SRC_DBG)  verdict = VRD_DROP;
        else                      verdict = VRD_FAULT;
    end
endmodule

// File: rtl/flg_guard.sv
module flg_guard
    import flg_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int PAGE_AW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_src,
    input  logic [2:0]           req_op,
    input  logic [PAGE_AW-1:0]   req_page,
    input  logic [PAGE_AW-1:0]   exec_page,
    input  logic [NUM_PAGES-1:0] lock_wdata,
    input  logic [NUM_PAGES-1:0] lock_stored,
    input  logic                 vmon_en,
    input  logic                 vmon_rst_src,
    output logic                 grant,
    output logic                 drop,
    output logic                 err_reset,
    output logic                 err_flag,
    output logic [NUM_PAGES-1:0] lock_active
);
    localparam int LOCK_PAGE = NUM_PAGES - 1;
    localparam int N_LOOK    = 2;   // 0: target page, 1: executing page

    typedef struct packed {
        logic                 grant;
        logic                 drop;
        logic                 fault;
        logic                 err_flag;
        logic                 load_pend;
        logic [NUM_PAGES-1:0] lock_active;
    } state_t;

    state_t st_d, st_q;

    flg_op_e              op_e;
    flg_verdict_e         verdict;
    logic                 dev_erase;
    logic [NUM_PAGES-1:0] lock_eff;
    logic [NUM_PAGES-1:0] locked_vec;
    logic                 any_locked;
    logic [PAGE_AW-1:0]   tgt_page;
    logic [PAGE_AW-1:0]   look_page [N_LOOK];
    logic [N_LOOK-1:0]    pg_locked;
    logic [N_LOOK-1:0]    pg_rsvd;
    logic                 tgt_is_lock;
    logic                 unlock_try;
    logic                 vmon_ok;

    always_comb begin
        op_e         = flg_op_e'(req_op);
        lock_eff     = st_q.load_pend ? lock_stored : st_q.lock_active;
        tgt_page     = (op_e == OP_LOCKWR) ? PAGE_AW'(LOCK_PAGE) : req_page;
        look_page[0] = tgt_page;
        look_page[1] = exec_page;
        tgt_is_lock  = (tgt_page == PAGE_AW'(LOCK_PAGE));
        unlock_try   = |(lock_wdata & ~lock_stored);
        vmon_ok      = vmon_en && vmon_rst_src;
    end

    flg_lock_map #(.NUM_PAGES(NUM_PAGES)) u_map (
        .lock_eff   (lock_eff),
        .locked_vec (locked_vec),
        .any_locked (any_locked)
    );

    for (genvar k = 0; k < N_LOOK; k++) begin : g_look
        flg_page_class #(.NUM_PAGES(NUM_PAGES), .PAGE_AW(PAGE_AW)) u_cls (
            .page       (look_page[k]),
            .locked_vec (locked_vec),
            .locked     (pg_locked[k]),
            .reserved   (pg_rsvd[k])
        );
    end

    flg_policy u_pol (
        .src         (req_src),
        .op          (op_e),
        .tgt_locked  (pg_locked[0]),
        .tgt_rsvd    (pg_rsvd[0]),
        .exec_locked (pg_locked[1]),
        .exec_rsvd   (pg_rsvd[1]),
        .tgt_is_lock (tgt_is_lock),
        .any_locked  (any_locked),
        .unlock_try  (unlock_try),
        .vmon_ok     (vmon_ok),
        .verdict     (verdict),
        .dev_erase   (dev_erase)
    );

    always_comb begin
        st_d             = st_q;
        st_d.grant       = 1'b0;
        st_d.drop        = 1'b0;
        st_d.fault       = 1'b0;
        st_d.load_pend   = 1'b0;
        st_d.lock_active = lock_eff;
        if (req_valid) begin
            case (verdict)
                VRD_GRANT: begin
                    st_d.grant = 1'b1;
                    if (dev_erase) st_d.lock_active = '1;
                end
                VRD_DROP: st_d.drop = 1'b1;
                default: begin
                    st_d.fault       = 1'b1;
                    st_d.err_flag    = 1'b1;
                    st_d.lock_active = lock_stored;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.load_pend <= 1'b1;
            st_q.lock_active <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant       = st_q.grant;
    assign drop        = st_q.drop;
    assign err_reset   = st_q.fault;
    assign err_flag    = st_q.err_flag;
    assign lock_active = st_q.lock_active;
endmodule

// File: rtl/flg_guard_chk.sv
module flg_guard_chk
    import flg_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int PAGE_AW   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_src,
    input logic [2:0]           req_op,
    input logic [PAGE_AW-1:0]   req_page,
    input logic                 vmon_en,
    input logic                 vmon_rst_src,
    input logic                 grant,
    input logic                 drop,
    input logic                 err_reset,
    input logic                 err_flag,
    input logic [NUM_PAGES-1:0] lock_active
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, drop, err_reset})); // R2

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || drop || err_reset)); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant || drop || err_reset)); // R2

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R5

    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset |-> err_flag); // R5

    AST_DEBUG_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == SRC_DBG) |=> !err_reset); // R6

    AST_LOCKWR_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && req_valid && req_op == OP_LOCKWR) |=> ($stable(lock_active) || err_reset)); // R8

    AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_page >= PAGE_AW'(NUM_PAGES) && req_op <= 3'd2) |=> !grant); // R10

    AST_SUPPLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == SRC_FW && req_op >= 3'd1 && req_op <= 3'd3
         && !(vmon_en && vmon_rst_src)) |=> err_reset); // R11
endmodule

bind flg_guard flg_guard_chk #(.NUM_PAGES(NUM_PAGES), .PAGE_AW(PAGE_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_src      (req_src),
    .req_op       (req_op),
    .req_page     (req_page),
    .vmon_en      (vmon_en),
    .vmon_rst_src (vmon_rst_src),
    .grant        (grant),
    .drop         (drop),
    .err_reset    (err_reset),
    .err_flag     (err_flag),
    .lock_active  (lock_active)
);

// File: tb/flg_guard_bench.sv
module flg_guard_bench;
    localparam int NP = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_src = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_page = '0;
    logic [AW-1:0] exec_page = '0;
    logic [NP-1:0] lock_wdata = '1;
    logic [NP-1:0] lock_stored = 8'hFF;
    logic          vmon_en = 1'b1;
    logic          vmon_rst_src = 1'b1;
    logic          grant, drop, err_reset, err_flag;
    logic [NP-1:0] lock_active;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  g;
        logic  d;
        logic  e;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    flg_guard #(.NUM_PAGES(NP), .PAGE_AW(AW)) u_flg_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_op(req_op), .req_page(req_page), .exec_page(exec_page),
        .lock_wdata(lock_wdata), .lock_stored(lock_stored), .vmon_en(vmon_en),
        .vmon_rst_src(vmon_rst_src), .grant(grant), .drop(drop),
        .err_reset(err_reset), .err_flag(err_flag), .lock_active(lock_active)
    );

    // monitor: pops one expected outcome per request, otherwise expects silence
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if ({grant, drop, err_reset} !== {e.g, e.d, e.e}) begin
                    fails++;
                    $display("FAIL %s: g/d/e actual %b%b%b expected %b%b%b",
                             e.tag, grant, drop, err_reset, e.g, e.d, e.e);
                end
            end else if ({grant, drop, err_reset} !== 3'b000) begin
                fails++;
                $display("FAIL R2 idle: g/d/e actual %b%b%b expected 000",
                         grant, drop, err_reset);
            end
        end
    end

    task automatic issue(input logic src, input logic [2:0] op, input logic [AW-1:0] pg,
                         input logic [AW-1:0] ex, input logic [NP-1:0] wd,
                         input logic eg, input logic ed, input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_op = op;
        req_page = pg; exec_page = ex; lock_wdata = wd;
        @(posedge clk);
        e.g = eg; e.d = ed; e.e = ee; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_state(input logic ef, input logic [NP-1:0] la, input string tag);
        tests++;
        if (err_flag !== ef || lock_active !== la) begin
            fails++;
            $display("FAIL %s: flag/lock actual %b/%h expected %b/%h",
                     tag, err_flag, lock_active, ef, la);
        end
    endtask

    task automatic do_reset(input logic [NP-1:0] after_lock);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        tests++;
        if ({grant, drop, err_reset, err_flag} !== 4'b0000) begin
            fails++;
            $display("FAIL R1 in reset: g/d/e/f actual %b%b%b%b expected 0000",
                     grant, drop, err_reset, err_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk_state(1'b0, after_lock, "R1 load after release");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset(8'hFF);
        // no locks
        issue(0, 3'd0, 4'd2, 4'd0, 8'hFF, 1, 0, 0, "R3 fw read unlocked");
        issue(0, 3'd0, 4'd9, 4'd0, 8'hFF, 0, 0, 1, "R10 fw read reserved");
        chk_state(1'b1, 8'hFF, "R5 flag set");
        // lock page 2 by firmware: deferred
        issue(0, 3'd3, 4'd0, 4'd0, 8'hFB, 1, 0, 0, "R7 lock clear-only write");
        lock_stored = 8'hFB;
        chk_state(1'b1, 8'hFF, "R8 lock not yet active");
        issue(0, 3'd0, 4'd2, 4'd0, 8'hFF, 1, 0, 0, "R8 old lock still in force");
        do_reset(8'hFB);   // R5 flag cleared, R8 lock now active
        issue(0, 3'd0, 4'd2, 4'd0, 8'hFF, 0, 0, 1, "R3 fw unlocked->locked");
        chk_state(1'b1, 8'hFB, "R5 flag after fault");
        issue(0, 3'd0, 4'd2, 4'd2, 8'hFF, 1, 0, 0, "R3 fw locked->locked");
        issue(0, 3'd0, 4'd3, 4'd0, 8'hFF, 1, 0, 0, "R3 fw unlocked page");
        issue(0, 3'd0, 4'd7, 4'd0, 8'hFF, 0, 0, 1, "R4 lock page implicit");
        issue(0, 3'd1, 4'd7, 4'd2, 8'hFF, 1, 0, 0, "R4 lock page from locked");
        issue(1, 3'd0, 4'd2, 4'd0, 8'hFF, 1, 0, 0, "R6 dbg read locked");
        issue(1, 3'd3, 4'd0, 4'd0, 8'hFF, 0, 1, 0, "R7 dbg unlock dropped");
        issue(0, 3'd3, 4'd0, 4'd2, 8'hFF, 0, 0, 1, "R7 fw unlock faults");
        issue(0, 3'd3, 4'd0, 4'd2, 8'hF3, 1, 0, 0, "R7 fw lock more");
        chk_state(1'b1, 8'hFB, "R8 lockwr deferred");
        issue(0, 3'd3, 4'd0, 4'd0, 8'hF3, 0, 0, 1, "R4 lockwr from unlocked");
        issue(1, 3'd2, 4'd7, 4'd0, 8'hFF, 0, 1, 0, "R9 dbg erase lock page");
        issue(0, 3'd2, 4'd7, 4'd2, 8'hFF, 0, 0, 1, "R9 fw erase lock page");
        issue(1, 3'd2, 4'd2, 4'd0, 8'hFF, 1, 0, 0, "R6 dbg erase locked");
        issue(1, 3'd0, 4'd12, 4'd0, 8'hFF, 0, 1, 0, "R10 dbg reserved");
        vmon_en = 1'b0;
        issue(0, 3'd1, 4'd3, 4'd0, 8'hFF, 0, 0, 1, "R11 write no monitor");
        issue(0, 3'd0, 4'd3, 4'd0, 8'hFF, 1, 0, 0, "R11 read no monitor");
        vmon_en = 1'b1;
        vmon_rst_src = 1'b0;
        issue(0, 3'd2, 4'd3, 4'd0, 8'hFF, 0, 0, 1, "R11 erase no rst src");
        vmon_rst_src = 1'b1;
        issue(1, 3'd5, 4'd0, 4'd0, 8'hFF, 0, 1, 0, "R2 unused op");
        issue(0, 3'd4, 4'd0, 4'd2, 8'hFF, 0, 0, 1, "R9 fw device erase");
        issue(1, 3'd4, 4'd0, 4'd0, 8'hFF, 1, 0, 0, "R9 dbg device erase");
        chk_state(1'b1, 8'hFF, "R9 locks cleared");
        lock_stored = 8'hFF;
        issue(0, 3'd0, 4'd2, 4'd0, 8'hFF, 1, 0, 0, "R9 page free after erase");
        do_reset(8'hFF);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule